// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

The tracker sits beside an SDRAM command bus and follows the commands sent to a four-bank device. It records, per bank, whether a row is open and which row that is. It also reports when the device is fully idle, meaning no row is open and no read burst is running. Commands are sampled on a rising clock edge while the valid strobe is high. They are decoded from the chip-select, row-strobe, column-strobe and write-enable lines, the bank-address bits and the address bus.

Three sticky error flags catch protocol misuse: an activate to a bank that already holds an open row, a read to a bank with no usable open row, and a mode-register load while the device is not idle. A read with address bit 10 high closes its bank when the burst ends. The burst lasts BURST_LEN/2 clock cycles. The block keeps no data-path state, and the column address of a read is not stored.

Top module: `sdram_row_tracker`

## Requirements
- R1: With valid high and chip-select low, {ras_ni,cas_ni,we_ni} encodes the commands: activate=011, read=101, write=100, precharge=010, mode load=000. No bank state changes when valid is low, when chip-select is high, or for a no-op (111), a write or any other code.
- R2: An activate to a closed bank sets bank_open_o[bank] and loads that bank's row field with addr_i. Both are visible after the command edge. Bank b's row is bank_row_o[b*ADDR_W +: ADDR_W].
- R3: An activate to a bank that is already open sets err_act_o. The bank stays open and its row field keeps its previous value.
- R4: A precharge with addr_i[10] low closes only the addressed bank. With addr_i[10] high it closes every bank.
- R5: A read to an open bank starts a burst of BURST_LEN/2 cycles, during which all_idle_o is low even if no bank is open. With addr_i[10] low the bank stays open after the burst.
- R6: A read with addr_i[10] high closes its bank on the edge BURST_LEN/2 cycles after the read's edge.
- R7: A read to a closed bank, or to a bank whose auto-close is still pending, sets err_rd_o. It starts no burst and does not alter the pending close.
- R8: A mode load while any bank is open or a burst is running sets err_lmr_o. A mode load at full idle sets no error. Neither case changes any bank.
- R9: All three error flags stay set until rst_ni is asserted.
- R10: all_idle_o is high exactly when no bank is open and no burst is running.
- R11: A legal read during a running burst restarts the burst count from the new read's edge. Any pending auto-close of the earlier read takes effect at that edge.
- R12: While rst_ni is low, every bank is closed, every row field is zero, the error flags are clear and all_idle_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command bus sample strobe |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Address bus (row, column, bit 10 qualifier) |
| bank_open_o | output | 4 | Per-bank open flag |
| bank_row_o | output | 52 | Per-bank open row, ADDR_W bits per bank |
| all_idle_o | output | 1 | No bank open and no burst running |
| err_act_o | output | 1 | Sticky: activate to an open bank |
| err_rd_o | output | 1 | Sticky: read to a closed or closing bank |
| err_lmr_o | output | 1 | Sticky: mode load while not idle |

## Verification
The open flags, row fields and error flags change on the first rising edge after the command is presented. An auto-close lands BURST_LEN/2 edges after the read's edge, and all_idle_o follows the same count. The bench drives every command on a falling edge. It samples one falling edge later, once for the next-edge results. For the burst results it waits BURST_LEN/2-1 further falling edges to confirm the bank is still open, then one more to see it closed. Restart and pending-close cases count from the edge of the command that caused them.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  localparam int unsigned AP_BIT = 10;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_LMR,
    CMD_REF
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic vld, input logic cs_n,
                                      input logic ras_n, input logic cas_n,
                                      input logic we_n);
    cmd_e c;
    c = CMD_NONE;
    if (vld && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b000:  c = CMD_LMR;
        3'b001:  c = CMD_REF;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 13,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 cmd_vld_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output cmd_e                 cmd_o,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic                 ap_o,
  output logic [ADDR_W-1:0]    row_o
);

  localparam logic [NUM_BANKS-1:0] ONE = NUM_BANKS'(1);

  always_comb begin
    cmd_o      = decode_cmd(cmd_vld_i, cs_ni, ras_ni, cas_ni, we_ni);
    bank_sel_o = ONE << ba_i;
    ap_o       = addr_i[AP_BIT];
    row_o      = addr_i;
  end

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_set_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic              close_i,
  output logic              open_o,
  output logic [ADDR_W-1:0] row_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (close_i) begin
      open_o <= 1'b0;
    end else if (open_set_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end
  end

endmodule

// File: rtl/sdram_trk_burst.sv
module sdram_trk_burst #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BURST_LEN = 8,
  localparam int unsigned BURST_CYC = (BURST_LEN < 2) ? 1 : BURST_LEN / 2,
  localparam int unsigned CNT_W     = $clog2(BURST_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 start_ap_i,
  input  logic [NUM_BANKS-1:0] start_bank_i,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] ap_pend_o,
  output logic [NUM_BANKS-1:0] ap_close_o
);

  logic [CNT_W-1:0]     cnt_q;
  logic                 ap_q;
  logic [NUM_BANKS-1:0] bank_q;
  logic                 last;

  assign last   = (cnt_q == CNT_W'(1));
  assign busy_o = (cnt_q != '0);

  // pending close fires at burst end or when a new read cuts the burst short
  always_comb begin
    ap_pend_o  = ap_q ? bank_q : '0;
    ap_close_o = (ap_q && (last || start_i)) ? bank_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(BURST_CYC);
      ap_q   <= start_ap_i;
      bank_q <= start_bank_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last) ap_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BURST_LEN = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_vld_i,
  input  logic                          cs_ni,
  input  logic                          ras_ni,
  input  logic                          cas_ni,
  input  logic                          we_ni,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [NUM_BANKS-1:0]          bank_open_o,
  output logic [NUM_BANKS*ADDR_W-1:0]   bank_row_o,
  output logic                          all_idle_o,
  output logic                          err_act_o,
  output logic                          err_rd_o,
  output logic                          err_lmr_o
);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] bank_sel;
  logic                 ap;
  logic [ADDR_W-1:0]    row;
  logic                 busy;
  logic [NUM_BANKS-1:0] ap_pend;
  logic [NUM_BANKS-1:0] ap_close;
  logic [NUM_BANKS-1:0] open_set;
  logic [NUM_BANKS-1:0] close;
  logic                 act_hit, act_bad, rd_ok, rd_bad, lmr_bad;

  sdram_trk_decode #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .cmd_vld_i (cmd_vld_i),
    .cs_ni     (cs_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .ba_i      (ba_i),
    .addr_i    (addr_i),
    .cmd_o     (cmd),
    .bank_sel_o(bank_sel),
    .ap_o      (ap),
    .row_o     (row)
  );

  always_comb begin
    act_hit  = |(bank_sel & bank_open_o);
    act_bad  = (cmd == CMD_ACT) && act_hit;
    rd_ok    = (cmd == CMD_RD) && |(bank_sel & bank_open_o & ~ap_pend);
    rd_bad   = (cmd == CMD_RD) && !rd_ok;
    lmr_bad  = (cmd == CMD_LMR) && (|bank_open_o || busy);
    open_set = ((cmd == CMD_ACT) && !act_hit) ? bank_sel : '0;
    close    = ap_close;
    if (cmd == CMD_PRE) close = close | (ap ? {NUM_BANKS{1'b1}} : bank_sel);
  end

  sdram_trk_burst #(
    .NUM_BANKS(NUM_BANKS),
    .BURST_LEN(BURST_LEN)
  ) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_ok),
    .start_ap_i  (ap),
    .start_bank_i(bank_sel),
    .busy_o      (busy),
    .ap_pend_o   (ap_pend),
    .ap_close_o  (ap_close)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_trk_bank #(
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .open_set_i(open_set[b]),
      .row_i     (row),
      .close_i   (close[b]),
      .open_o    (bank_open_o[b]),
      .row_o     (bank_row_o[b*ADDR_W +: ADDR_W])
    );
  end

  assign all_idle_o = ~(|bank_open_o) & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_act_o <= 1'b0;
      err_rd_o  <= 1'b0;
      err_lmr_o <= 1'b0;
    end else begin
      err_act_o <= err_act_o | act_bad;
      err_rd_o  <= err_rd_o | rd_bad;
      err_lmr_o <= err_lmr_o | lmr_bad;
    end
  end

endmodule

// File: rtl/sdram_row_tracker_chk.sv
module sdram_row_tracker_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 13,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cmd_vld_i,
  input logic                        cs_ni,
  input logic                        ras_ni,
  input logic                        cas_ni,
  input logic                        we_ni,
  input logic [BA_W-1:0]             ba_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [NUM_BANKS-1:0]        bank_open_o,
  input logic [NUM_BANKS*ADDR_W-1:0] bank_row_o,
  input logic                        all_idle_o,
  input logic                        err_act_o,
  input logic                        err_rd_o,
  input logic                        err_lmr_o
);

  logic sel, act_c, rd_c, pre_c, lmr_c;
  assign sel   = cmd_vld_i && !cs_ni;
  assign act_c = sel && ({ras_ni, cas_ni, we_ni} == 3'b011);
  assign rd_c  = sel && ({ras_ni, cas_ni, we_ni} == 3'b101);
  assign pre_c = sel && ({ras_ni, cas_ni, we_ni} == 3'b010);
  assign lmr_c = sel && ({ras_ni, cas_ni, we_ni} == 3'b000);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BA_W'(b));

    assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_c && hit && !bank_open_o[b] |=>
        bank_open_o[b] && (bank_row_o[b*ADDR_W +: ADDR_W] == $past(addr_i)));

    assert_dup_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_c && hit && bank_open_o[b] |=>
        err_act_o && $stable(bank_row_o[b*ADDR_W +: ADDR_W]));

    assert_rd_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_c && hit && !bank_open_o[b] |=> err_rd_o);

    assert_no_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel && !bank_open_o[b] |=> !bank_open_o[b]);
  end

  assert_pre_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_c && addr_i[10] |=> bank_open_o == '0);

  assert_lmr_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmr_c && (|bank_open_o) |=> err_lmr_o);

  assert_act_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_act_o |=> err_act_o);

  assert_rd_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rd_o |=> err_rd_o);

  assert_lmr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lmr_o |=> err_lmr_o);

  assert_idle_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_o |-> (bank_open_o == '0));

endmodule

bind sdram_row_tracker sdram_row_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_vld_i  (cmd_vld_i),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .ba_i       (ba_i),
  .addr_i     (addr_i),
  .bank_open_o(bank_open_o),
  .bank_row_o (bank_row_o),
  .all_idle_o (all_idle_o),
  .err_act_o  (err_act_o),
  .err_rd_o   (err_rd_o),
  .err_lmr_o  (err_lmr_o)
);

// File: tb/sdram_row_tracker_test.sv
module sdram_row_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int AW         = 13;
  localparam int BURST_LEN  = 8;
  localparam int BC         = BURST_LEN / 2;

  localparam logic [2:0] E_ACT = 3'b011;
  localparam logic [2:0] E_RD  = 3'b101;
  localparam logic [2:0] E_WR  = 3'b100;
  localparam logic [2:0] E_PRE = 3'b010;
  localparam logic [2:0] E_LMR = 3'b000;
  localparam logic [2:0] E_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic cs_n = 1'b1;
  logic [2:0] rcw = E_NOP;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] open_w;
  logic [NB*AW-1:0] row_w;
  logic idle_w, e_act, e_rd, e_lmr;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_row_tracker #(
    .NUM_BANKS(NB),
    .ADDR_W   (AW),
    .BURST_LEN(BURST_LEN)
  ) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_vld_i  (vld),
    .cs_ni      (cs_n),
    .ras_ni     (rcw[2]),
    .cas_ni     (rcw[1]),
    .we_ni      (rcw[0]),
    .ba_i       (ba),
    .addr_i     (addr),
    .bank_open_o(open_w),
    .bank_row_o (row_w),
    .all_idle_o (idle_w),
    .err_act_o  (e_act),
    .err_rd_o   (e_rd),
    .err_lmr_o  (e_lmr)
  );

  function automatic logic [AW-1:0] row_of(input int b);
    return row_w[b*AW +: AW];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0; cs_n = 1'b1; rcw = E_NOP;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at a falling edge, hold across one rising edge, then release
  task automatic issue(input logic v, input logic c, input logic [2:0] e,
                       input logic [1:0] b, input logic [AW-1:0] a);
    vld = v; cs_n = c; rcw = e; ba = b; addr = a;
    @(negedge clk);
    vld = 1'b0; cs_n = 1'b1; rcw = E_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic act(input logic [1:0] b, input logic [AW-1:0] r);
    issue(1'b1, 1'b0, E_ACT, b, r);
  endtask

  task automatic rd(input logic [1:0] b, input logic apb);
    issue(1'b1, 1'b0, E_RD, b, AW'({apb, 10'h005}));
  endtask

  task automatic pre(input logic [1:0] b, input logic all);
    issue(1'b1, 1'b0, E_PRE, b, AW'({all, 10'h000}));
  endtask

  task automatic t_reset();
    apply_reset();
    check("R12", "open after reset", 64'(open_w), 64'h0);
    check("R12", "rows after reset", 64'(row_w), 64'h0);
    check("R12", "idle after reset", 64'(idle_w), 64'h1);
    check("R12", "errors after reset", 64'({e_act, e_rd, e_lmr}), 64'h0);
  endtask

  task automatic t_open();
    apply_reset();
    act(2'd0, 13'h1234);
    act(2'd2, 13'h0abc);
    check("R2", "open flags", 64'(open_w), 64'h5);
    check("R2", "row bank0", 64'(row_of(0)), 64'h1234);
    check("R2", "row bank2", 64'(row_of(2)), 64'h0abc);
    check("R10", "idle with open banks", 64'(idle_w), 64'h0);
    issue(1'b1, 1'b1, E_ACT, 2'd1, 13'h0111);   // chip-select high
    issue(1'b0, 1'b0, E_ACT, 2'd1, 13'h0222);   // valid low
    issue(1'b1, 1'b0, E_NOP, 2'd1, 13'h0333);
    issue(1'b1, 1'b0, E_WR,  2'd0, 13'h0444);
    issue(1'b1, 1'b1, E_PRE, 2'd0, 13'h1400);   // deselected precharge-all
    check("R1", "open after ignored cmds", 64'(open_w), 64'h5);
    check("R1", "row bank0 after ignored", 64'(row_of(0)), 64'h1234);
    check("R1", "no error from ignored", 64'({e_act, e_rd, e_lmr}), 64'h0);
  endtask

  task automatic t_dup_act();
    apply_reset();
    act(2'd1, 13'h0055);
    act(2'd1, 13'h0077);
    check("R3", "err_act", 64'(e_act), 64'h1);
    check("R3", "row kept", 64'(row_of(1)), 64'h0055);
    check("R3", "bank still open", 64'(open_w), 64'h2);
    check("R3", "other errors", 64'({e_rd, e_lmr}), 64'h0);
  endtask

  task automatic t_precharge();
    apply_reset();
    act(2'd0, 13'h0001);
    act(2'd1, 13'h0002);
    act(2'd3, 13'h0003);
    pre(2'd1, 1'b0);
    check("R4", "single close", 64'(open_w), 64'h9);
    pre(2'd0, 1'b1);
    check("R4", "close all", 64'(open_w), 64'h0);
    check("R10", "idle after close all", 64'(idle_w), 64'h1);
  endtask

  task automatic t_read_open();
    apply_reset();
    act(2'd2, 13'h0009);
    rd(2'd2, 1'b0);
    idle(BC);
    check("R5", "open after plain read burst", 64'(open_w), 64'h4);
    rd(2'd2, 1'b0);
    pre(2'd2, 1'b0);
    check("R5", "bank closed by precharge", 64'(open_w), 64'h0);
    check("R5", "idle low in burst", 64'(idle_w), 64'h0);
    idle(BC - 2);
    check("R10", "idle low last burst cycle", 64'(idle_w), 64'h0);
    idle(1);
    check("R10", "idle high after burst", 64'(idle_w), 64'h1);
    check("R5", "no read error", 64'(e_rd), 64'h0);
  endtask

  task automatic t_read_ap();
    apply_reset();
    act(2'd3, 13'h1fff);
    rd(2'd3, 1'b1);
    idle(BC - 1);
    check("R6", "open before burst end", 64'(open_w), 64'h8);
    check("R6", "not idle before end", 64'(idle_w), 64'h0);
    idle(1);
    check("R6", "closed at burst end", 64'(open_w), 64'h0);
    check("R6", "idle at burst end", 64'(idle_w), 64'h1);
  endtask

  task automatic t_read_bad();
    apply_reset();
    rd(2'd0, 1'b0);
    check("R7", "err_rd closed bank", 64'(e_rd), 64'h1);
    check("R7", "no burst from bad read", 64'(idle_w), 64'h1);
    apply_reset();
    act(2'd1, 13'h0042);
    rd(2'd1, 1'b1);
    rd(2'd1, 1'b0);
    check("R7", "err_rd pending close", 64'(e_rd), 64'h1);
    idle(BC - 2);
    check("R7", "still open", 64'(open_w), 64'h2);
    idle(1);
    check("R7", "closes on original count", 64'(open_w), 64'h0);
  endtask

  task automatic t_interrupt();
    apply_reset();
    act(2'd1, 13'h0011);
    act(2'd3, 13'h0033);
    rd(2'd1, 1'b1);
    rd(2'd3, 1'b1);
    check("R11", "earlier bank closed at cut", 64'(open_w), 64'h8);
    check("R11", "no read error", 64'(e_rd), 64'h0);
    idle(BC - 1);
    check("R11", "restarted burst open", 64'(open_w), 64'h8);
    idle(1);
    check("R11", "restarted burst closes", 64'(open_w), 64'h0);
    check("R10", "idle after restart", 64'(idle_w), 64'h1);
  endtask

  task automatic t_lmr();
    apply_reset();
    issue(1'b1, 1'b0, E_LMR, 2'd0, 13'h0032);
    check("R8", "legal mode load", 64'(e_lmr), 64'h0);
    act(2'd0, 13'h0100);
    issue(1'b1, 1'b0, E_LMR, 2'd0, 13'h0032);
    check("R8", "mode load with open bank", 64'(e_lmr), 64'h1);
    check("R8", "bank unchanged", 64'(open_w), 64'h1);
    apply_reset();
    act(2'd0, 13'h0100);
    rd(2'd0, 1'b1);
    pre(2'd0, 1'b0);
    check("R8", "bank closed, burst on", 64'({open_w, idle_w}), 64'h0);
    issue(1'b1, 1'b0, E_LMR, 2'd0, 13'h0032);
    check("R8", "mode load during burst", 64'(e_lmr), 64'h1);
  endtask

  task automatic t_sticky();
    apply_reset();
    act(2'd0, 13'h0001);
    act(2'd0, 13'h0002);
    rd(2'd2, 1'b0);
    issue(1'b1, 1'b0, E_LMR, 2'd0, 13'h0000);
    pre(2'd0, 1'b1);
    idle(BC + 2);
    issue(1'b1, 1'b0, E_LMR, 2'd0, 13'h0000);
    act(2'd1, 13'h0005);
    check("R9", "errors held", 64'({e_act, e_rd, e_lmr}), 64'h7);
    apply_reset();
    check("R9", "errors cleared by reset", 64'({e_act, e_rd, e_lmr}), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_open();
    t_dup_act();
    t_precharge();
    t_read_open();
    t_read_ap();
    t_read_bad();
    t_interrupt();
    t_lmr();
    t_sticky();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule